// File: doc/BRIEF.md
# Tone Steering and Guard-Time Validator

This block sits behind a dual-tone detector and decides when a detected tone pair counts as a real key press. The detector supplies a raw "tone present" indication and the 4-bit code of the pair it hears. The block requires that indication to stay high for a programmable number of clock cycles before the code is taken. It also requires the indication to stay low for a second, separately programmable number of cycles before the tone is considered finished and a new one may be accepted. Short bursts of speech-like energy are therefore rejected, and short dropouts in a genuine tone are ridden through.

When a tone qualifies, its code is written into a receive register. A validity flag follows two cycles later, so that any reader that sees the flag also sees settled data. The flag stays up until the pause guard expires. An active-low interrupt request follows the flag whenever interrupts are enabled. The two guard times replace an external RC steering network with plain cycle counters.

Top module: `tone_steer`

## Requirements
- R1: While reset is held and right after it, `valid_o` is 0, `rx_code_o` is 0 and `irq_no` is 1.
- R2: A tone whose detect input stays high for fewer consecutive samples than `on_guard_i` leaves `rx_code_o` and `valid_o` unchanged.
- R3: On the clock edge that takes the `on_guard_i`-th consecutive high sample of `tone_det_i`, with the block waiting for a tone, `rx_code_o` loads the value of `code_i` sampled on that edge.
- R4: `valid_o` rises exactly two clock edges after the edge that loaded `rx_code_o`.
- R5: `rx_code_o` changes only while `valid_o` is low, and never on the edge that raises or lowers it.
- R6: While `valid_o` is high, a run of low samples on `tone_det_i` shorter than `off_guard_i` keeps `valid_o` high.
- R7: While `valid_o` is high, it clears on the edge that takes the `off_guard_i`-th consecutive low sample of `tone_det_i`. From the next edge on, a new tone is qualified from scratch.
- R8: While `valid_o` is high, changes on `code_i` and renewed tone activity do not alter `rx_code_o`.
- R9: `irq_no` is 0 exactly when `valid_o` is 1 and `irq_en_i` is 1. Otherwise it is 1.
- R10: A guard value of 0 behaves the same as a guard value of 1.
- R11: `tone_det_i` is ignored during the two cycles between loading the code and raising `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tone_det_i | input | 1 | Raw tone-pair-present indication from the detector |
| code_i | input | 4 | Code of the detected tone pair |
| on_guard_i | input | 16 | Tone-present guard, in clock cycles |
| off_guard_i | input | 16 | Tone-absent guard, in clock cycles |
| irq_en_i | input | 1 | Enables the interrupt request |
| rx_code_o | output | 4 | Receive data register |
| valid_o | output | 1 | Delayed validity flag |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bound checker watches several relations on every cycle. It checks that the receive register moves only while the flag is low and is followed two edges later by the flag. It checks that the flag never falls while the tone is present and only rises three cycles after a high detect sample. It also checks the frozen data while the flag is high and the interrupt/flag relation. The exact guard lengths are checked only by the bench: that a run of N-1 samples is rejected and a run of N accepted, the zero-guard case, and that detect activity in the settle window is ignored. The bench covers these with directed runs and long random runs against a cycle model.

// File: rtl/tone_steer_pkg.sv
package tone_steer_pkg;
  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HELD   = 2'd2
  } st_e;

  localparam int unsigned NUM_GUARDS = 2;
  localparam int unsigned G_ON  = 0;
  localparam int unsigned G_OFF = 1;
endpackage

// File: rtl/tone_steer_timer.sv
module tone_steer_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim_m1;

  // a limit of zero behaves as one
  assign lim_m1 = (limit_i == '0) ? '0 : limit_i - W'(1);
  assign hit_o  = en_i && (cnt_q >= lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i && (cnt_q != '1)) begin
      cnt_q <= cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/tone_steer_fsm.sv
module tone_steer_fsm
  import tone_steer_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tone_i,
  input  logic on_hit_i,
  input  logic off_hit_i,
  output logic on_en_o,
  output logic on_clr_o,
  output logic off_en_o,
  output logic off_clr_o,
  output logic latch_o,
  output logic set_o,
  output logic drop_o
);
  localparam int unsigned SW = $clog2(SETTLE_CYC + 1);

  st_e           st_q, st_d;
  logic [SW-1:0] stl_q, stl_d;
  logic          stl_done;

  assign stl_done = (stl_q == SW'(SETTLE_CYC - 1));

  always_comb begin
    on_en_o   = (st_q == ST_WAIT) && tone_i;
    on_clr_o  = (st_q != ST_WAIT) || !tone_i || on_hit_i;
    off_en_o  = (st_q == ST_HELD) && !tone_i;
    off_clr_o = (st_q != ST_HELD) || tone_i || off_hit_i;
    latch_o   = (st_q == ST_WAIT) && on_hit_i;
    set_o     = (st_q == ST_SETTLE) && stl_done;
    drop_o    = (st_q == ST_HELD) && off_hit_i;
  end

  always_comb begin
    st_d  = st_q;
    stl_d = stl_q;
    unique case (st_q)
      ST_WAIT: begin
        if (on_hit_i) begin
          st_d  = ST_SETTLE;
          stl_d = '0;
        end
      end
      ST_SETTLE: begin
        // detect input deliberately ignored here
        if (stl_done) st_d = ST_HELD;
        else          stl_d = stl_q + SW'(1);
      end
      ST_HELD: begin
        if (off_hit_i) st_d = ST_WAIT;
      end
      default: st_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_WAIT;
      stl_q <= '0;
    end else begin
      st_q  <= st_d;
      stl_q <= stl_d;
    end
  end
endmodule

// File: rtl/tone_steer_out.sv
module tone_steer_out #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_i,
  input  logic              set_i,
  input  logic              drop_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              irq_en_i,
  output logic [CODE_W-1:0] rx_code_o,
  output logic              valid_o,
  output logic              irq_no
);
  logic [CODE_W-1:0] rx_q;
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      if (latch_i) rx_q <= code_i;
      if (set_i)       vld_q <= 1'b1;
      else if (drop_i) vld_q <= 1'b0;
    end
  end

  assign rx_code_o = rx_q;
  assign valid_o   = vld_q;
  assign irq_no    = ~(vld_q & irq_en_i);
endmodule

// File: rtl/tone_steer.sv
module tone_steer
  import tone_steer_pkg::*;
#(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned GUARD_W    = 16,
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tone_det_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic [GUARD_W-1:0] on_guard_i,
  input  logic [GUARD_W-1:0] off_guard_i,
  input  logic               irq_en_i,
  output logic [CODE_W-1:0]  rx_code_o,
  output logic               valid_o,
  output logic               irq_no
);
  logic [NUM_GUARDS-1:0] g_en, g_clr, g_hit;
  logic [GUARD_W-1:0]    g_lim [NUM_GUARDS];
  logic                  latch, set_flag, drop_flag;

  assign g_lim[G_ON]  = on_guard_i;
  assign g_lim[G_OFF] = off_guard_i;

  for (genvar g = 0; g < NUM_GUARDS; g++) begin : g_timer
    tone_steer_timer #(.W(GUARD_W)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (g_en[g]),
      .clr_i   (g_clr[g]),
      .limit_i (g_lim[g]),
      .hit_o   (g_hit[g])
    );
  end

  tone_steer_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tone_i    (tone_det_i),
    .on_hit_i  (g_hit[G_ON]),
    .off_hit_i (g_hit[G_OFF]),
    .on_en_o   (g_en[G_ON]),
    .on_clr_o  (g_clr[G_ON]),
    .off_en_o  (g_en[G_OFF]),
    .off_clr_o (g_clr[G_OFF]),
    .latch_o   (latch),
    .set_o     (set_flag),
    .drop_o    (drop_flag)
  );

  tone_steer_out #(.CODE_W(CODE_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .latch_i   (latch),
    .set_i     (set_flag),
    .drop_i    (drop_flag),
    .code_i    (code_i),
    .irq_en_i  (irq_en_i),
    .rx_code_o (rx_code_o),
    .valid_o   (valid_o),
    .irq_no    (irq_no)
  );
endmodule

// File: rtl/tone_steer_chk.sv
module tone_steer_chk #(
  parameter int unsigned CODE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tone_det_i,
  input logic              irq_en_i,
  input logic [CODE_W-1:0] rx_code_o,
  input logic              valid_o,
  input logic              irq_no
);
  logic [1:0] seen_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              seen_q <= 2'd0;
    else if (seen_q != 2'd3)  seen_q <= seen_q + 2'd1;
  end
  assign warm = (seen_q == 2'd3);

  AST_CODE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && rx_code_o != $past(rx_code_o)) |-> (!valid_o && !$past(valid_o))); // R5

  AST_FLAG_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && rx_code_o != $past(rx_code_o)) |=> (!valid_o ##1 valid_o)); // R4

  AST_RISE_NEEDS_TONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $rose(valid_o)) |-> $past(tone_det_i, 3)); // R2

  AST_FALL_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $fell(valid_o)) |-> !$past(tone_det_i)); // R7

  AST_HOLD_WHILE_TONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && tone_det_i) |=> valid_o); // R6

  AST_RX_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> $stable(rx_code_o)); // R8

  AST_IRQ_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (valid_o && irq_en_i)); // R9

  AST_IRQ_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && irq_en_i) |-> !irq_no); // R9
endmodule

bind tone_steer tone_steer_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tone_det_i (tone_det_i),
  .irq_en_i   (irq_en_i),
  .rx_code_o  (rx_code_o),
  .valid_o    (valid_o),
  .irq_no     (irq_no)
);

// File: tb/tone_steer_test.sv
module tone_steer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 32'h5eed_0d1a;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tone = 1'b0;
  logic [3:0]  code = '0;
  logic [15:0] on_g = 16'd5;
  logic [15:0] off_g = 16'd4;
  logic        irq_en = 1'b0;
  logic [3:0]  rx_code;
  logic        valid;
  logic        irq_n;

  int total = 0;
  int bad = 0;
  bit mon_on = 1'b0;

  // cycle model
  int m_st = 0, m_h = 0, m_l = 0, m_s = 0;
  int m_code = 0;
  int m_valid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_steer uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tone_det_i  (tone),
    .code_i      (code),
    .on_guard_i  (on_g),
    .off_guard_i (off_g),
    .irq_en_i    (irq_en),
    .rx_code_o   (rx_code),
    .valid_o     (valid),
    .irq_no      (irq_n)
  );

  function automatic int eff(input int g);
    return (g == 0) ? 1 : g; // R10
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_h = 0; m_l = 0; m_s = 0; m_code = 0; m_valid = 0;
    end else begin
      case (m_st)
        0: begin
          if (tone) begin
            m_h++;
            if (m_h >= eff(int'(on_g))) begin
              m_code = int'(code); m_st = 1; m_s = 0; m_h = 0;
            end
          end else m_h = 0;
        end
        1: begin
          m_s++; // R11: tone ignored
          if (m_s == 2) begin m_valid = 1; m_st = 2; m_l = 0; end
        end
        default: begin
          if (!tone) begin
            m_l++;
            if (m_l >= eff(int'(off_g))) begin m_valid = 0; m_st = 0; m_h = 0; end
          end else m_l = 0;
        end
      endcase
    end
    #3;
    if (rst_n && mon_on) begin
      check("R4", int'(valid), m_valid);
      check("R3", int'(rx_code), m_code);
      check("R9", int'(irq_n), (m_valid == 1 && irq_en) ? 0 : 1);
    end
  end

  task automatic cyc(input logic t, input logic [3:0] c, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tone = t;
      code = c;
    end
  endtask

  task automatic peek;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog all-requirements got=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    int run_left;
    void'($urandom(SEED));
    #(CLK_PERIOD * 2 + 1);
    // R1 during reset
    check("R1", int'(valid), 0);
    check("R1", int'(rx_code), 0);
    check("R1", int'(irq_n), 1);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    peek();
    check("R1", int'(valid), 0);

    // R2: four-sample tone with guard of five
    cyc(1'b1, 4'd3, 4);
    cyc(1'b0, 4'd0, 6);
    peek();
    check("R2", int'(valid), 0);
    check("R2", int'(rx_code), 0);

    // R3 / R4: qualifying tone
    cyc(1'b1, 4'd9, 8);
    peek();
    check("R3", int'(rx_code), 9);
    check("R4", int'(valid), 1);

    // R6 / R8: short dropout, then new code while held
    cyc(1'b0, 4'd0, 3);
    cyc(1'b1, 4'd6, 3);
    peek();
    check("R6", int'(valid), 1);
    check("R8", int'(rx_code), 9);

    // R9: interrupt follows flag when enabled
    @(negedge clk); irq_en = 1'b1;
    peek();
    check("R9", int'(irq_n), 0);
    @(negedge clk); irq_en = 1'b0;
    peek();
    check("R9", int'(irq_n), 1);

    // R7: full pause clears flag
    cyc(1'b0, 4'd0, 3);
    peek();
    check("R7", int'(valid), 1);
    cyc(1'b0, 4'd0, 1);
    peek();
    check("R7", int'(valid), 0);

    // R10: zero guards, one-sample tone registers
    @(negedge clk); on_g = 16'd0; off_g = 16'd0;
    cyc(1'b1, 4'd12, 1);
    cyc(1'b0, 4'd0, 5);
    peek();
    check("R10", int'(rx_code), 12);
    check("R10", int'(valid), 0);

    // R11: low detect during settle ignored
    @(negedge clk); on_g = 16'd2; off_g = 16'd3;
    cyc(1'b1, 4'd5, 2);
    cyc(1'b0, 4'd0, 2);
    peek();
    check("R11", int'(valid), 1);
    check("R11", int'(rx_code), 5);
    cyc(1'b0, 4'd0, 4);

    // random phase, checked by the cycle model (R3 R4 R5 R9 each cycle)
    run_left = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (run_left == 0) begin
        tone = ~tone;
        run_left = 1 + int'($urandom_range(0, 11));
        code = 4'($urandom_range(0, 15));
      end
      run_left--;
      if ($urandom_range(0, 15) == 0) code = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 15) == 0) irq_en = ~irq_en;
      if ($urandom_range(0, 199) == 0) begin
        on_g  = 16'($urandom_range(0, 10));
        off_g = 16'($urandom_range(0, 10));
      end
    end
    cyc(1'b0, 4'd0, 20);
    mon_on = 1'b0;
    summary();
    $finish;
  end
endmodule